// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading a two-level page table from memory. A root pointer input gives the frame that holds the top-level directory. The walker reads one directory entry, and if that entry marks a leaf table as present, it reads one leaf entry. It then returns either the translated address or a fault code together with the virtual address that faulted.

Memory is reached through a single word-read port. The request phase uses a valid/ready handshake, and the response arrives after any number of cycles. The walker serves one translation at a time and refuses new requests until the current walk has reported. A page is 4 KB. Each table is 1024 entries of 4 bytes, so every table fills exactly one page.

Top module: `vxlate_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rd_valid` and `done_valid` are 0.
- R2: The first read goes to the directory entry at `{root_ptr[31:12], 12'h000} + vaddr[31:22]*4`. The low 12 bits of `root_ptr` are ignored.
- R3: If bit 0 (present) of the directory entry is 0, the walk ends after exactly one read and reports `done_code` = 2'b01 (leaf table missing).
- R4: The second read goes to the leaf entry at `{dir_entry[31:12], 12'h000} + vaddr[21:12]*4`. Directory-entry bits 11:1 are ignored.
- R5: If bit 0 of the leaf entry is 0, the walk reports `done_code` = 2'b10 (page missing).
- R6: If the leaf entry is present, the walk reports `done_code` = 2'b00 and `done_paddr` = `{leaf_entry[31:12], vaddr[11:0]}`.
- R7: From the cycle after a request is accepted until the result has been reported, `req_ready` is 0 and `req_valid` has no effect. The result belongs to the request that was accepted.
- R8: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_addr` stays unchanged. Any latency on either phase of the read is tolerated.
- R9: Each accepted request gives exactly one single-cycle `done_valid` pulse, with `done_vaddr` equal to the requested address. The walker is idle again on the next cycle.
- R10: A walk issues at most two reads, and a successful walk issues exactly two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_ptr | input | 32 | Directory base; bits 31:12 used |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 32 | Byte address of the entry being read |
| rsp_valid | input | 1 | Read data is valid |
| rsp_data | input | 32 | Entry word returned by memory |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 32 | Physical address (meaningful when code is 00) |
| done_vaddr | output | 32 | Virtual address of the finished walk |
| done_code | output | 2 | 00 ok, 01 leaf table missing, 10 page missing |

## Verification
The checker watches every cycle for the following:
- the read request holding steady while it stalls;
- `req_ready` staying low during a walk;
- the result strobe lasting one cycle;
- the read count per walk matching its outcome;
- the offset passing through on success;
- fault codes never setting both bits.

The directed scenarios are the only place the following are shown:
- the exact entry addresses built from the index fields and the entry frame fields;
- the translated frame;
- low bits of the root pointer and the entries being ignored;
- a second request presented mid-walk leaving the result unchanged.

// File: rtl/vxlate_pkg.sv
package vxlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ1  = 3'd1,
    ST_WAIT1 = 3'd2,
    ST_REQ2  = 3'd3,
    ST_WAIT2 = 3'd4,
    ST_DONE  = 3'd5
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_NO_TABLE = 2'b01,
    FLT_NO_PAGE  = 2'b10
  } flt_e;

  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned ENTRY_LOG2  = 2;

endpackage

// File: rtl/vxlate_addr_gen.sv
module vxlate_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned LEVELS = 2
) (
  input  logic [ADDR_W-1:0]        vaddr,
  input  logic [ADDR_W-OFF_W-1:0]  root_base,
  input  logic [ADDR_W-OFF_W-1:0]  tbl_base,
  input  logic                     lvl,
  output logic [ADDR_W-1:0]        ent_addr
);
  import vxlate_pkg::*;

  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  logic [IDX_W-1:0]   idx [LEVELS];
  logic [FRAME_W-1:0] base_sel;
  logic               unused_off;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign unused_off = ^vaddr[OFF_W-1:0];

  always_comb begin
    base_sel = lvl ? tbl_base : root_base;
    ent_addr = {base_sel, {OFF_W{1'b0}}} + (ADDR_W'(idx[lvl]) << ENTRY_LOG2);
  end

endmodule

// File: rtl/vxlate_pte_dec.sv
module vxlate_pte_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0]       entry,
  output logic                    present,
  output logic [ADDR_W-OFF_W-1:0] frame
);
  import vxlate_pkg::*;

  logic unused_attr;

  assign present     = entry[PRESENT_BIT];
  assign frame       = entry[ADDR_W-1:OFF_W];
  assign unused_attr = ^entry[OFF_W-1:PRESENT_BIT+1];

endmodule

// File: rtl/vxlate_ctrl.sv
module vxlate_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 rd_ready,
  input  logic                 rsp_valid,
  input  logic                 ent_present,
  output logic                 req_ready,
  output logic                 rd_valid,
  output logic                 lvl,
  output logic                 done_valid,
  output logic                 cap_req,
  output logic                 cap_tbl,
  output logic                 cap_res,
  output vxlate_pkg::flt_e     res_code
);
  import vxlate_pkg::*;

  walk_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    cap_req  = 1'b0;
    cap_tbl  = 1'b0;
    cap_res  = 1'b0;
    res_code = FLT_NONE;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          st_d    = ST_REQ1;
        end
      end
      ST_REQ1:  if (rd_ready) st_d = ST_WAIT1;
      ST_WAIT1: begin
        if (rsp_valid) begin
          if (ent_present) begin
            cap_tbl = 1'b1;
            st_d    = ST_REQ2;
          end else begin
            cap_res  = 1'b1;
            res_code = FLT_NO_TABLE;
            st_d     = ST_DONE;
          end
        end
      end
      ST_REQ2:  if (rd_ready) st_d = ST_WAIT2;
      ST_WAIT2: begin
        if (rsp_valid) begin
          cap_res  = 1'b1;
          res_code = ent_present ? FLT_NONE : FLT_NO_PAGE;
          st_d     = ST_DONE;
        end
      end
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rd_valid   = (st_q == ST_REQ1) || (st_q == ST_REQ2);
  assign lvl        = (st_q == ST_REQ2);
  assign done_valid = (st_q == ST_DONE);

endmodule

// File: rtl/vxlate_walker.sv
module vxlate_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] root_ptr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_data,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_paddr,
  output logic [ADDR_W-1:0] done_vaddr,
  output logic [1:0]        done_code
);
  import vxlate_pkg::*;

  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned LEVELS  = FRAME_W / IDX_W;

  logic               cap_req, cap_tbl, cap_res, lvl, ent_present;
  flt_e               res_code;
  logic [FRAME_W-1:0] ent_frame;
  logic               unused_root_lo;

  logic [ADDR_W-1:0]  vaddr_q, vaddr_d;
  logic [FRAME_W-1:0] root_q, root_d;
  logic [FRAME_W-1:0] tbl_q, tbl_d;
  logic [ADDR_W-1:0]  paddr_q, paddr_d;
  logic [1:0]         code_q, code_d;

  assign unused_root_lo = ^root_ptr[OFF_W-1:0];

  vxlate_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rd_ready    (rd_ready),
    .rsp_valid   (rsp_valid),
    .ent_present (ent_present),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .lvl         (lvl),
    .done_valid  (done_valid),
    .cap_req     (cap_req),
    .cap_tbl     (cap_tbl),
    .cap_res     (cap_res),
    .res_code    (res_code)
  );

  vxlate_addr_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .LEVELS (LEVELS)
  ) u_agen (
    .vaddr     (vaddr_q),
    .root_base (root_q),
    .tbl_base  (tbl_q),
    .lvl       (lvl),
    .ent_addr  (rd_addr)
  );

  vxlate_pte_dec #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_dec (
    .entry   (rsp_data),
    .present (ent_present),
    .frame   (ent_frame)
  );

  always_comb begin
    vaddr_d = vaddr_q;
    root_d  = root_q;
    tbl_d   = tbl_q;
    paddr_d = paddr_q;
    code_d  = code_q;
    if (cap_req) begin
      vaddr_d = req_vaddr;
      root_d  = root_ptr[ADDR_W-1:OFF_W];
    end
    if (cap_tbl) tbl_d = ent_frame;
    if (cap_res) begin
      code_d  = res_code;
      paddr_d = (res_code == FLT_NONE) ? {ent_frame, vaddr_q[OFF_W-1:0]} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
      code_q  <= FLT_NONE;
    end else begin
      vaddr_q <= vaddr_d;
      root_q  <= root_d;
      tbl_q   <= tbl_d;
      paddr_q <= paddr_d;
      code_q  <= code_d;
    end
  end

  assign done_paddr = paddr_q;
  assign done_vaddr = vaddr_q;
  assign done_code  = code_q;

endmodule

// File: rtl/vxlate_walker_chk.sv
module vxlate_walker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done_valid,
  input logic [1:0]        done_code,
  input logic [ADDR_W-1:0] done_paddr,
  input logic [ADDR_W-1:0] done_vaddr
);
  logic [1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rd_cnt <= 2'd0;
    else if (req_valid && req_ready)  rd_cnt <= 2'd0;
    else if (rd_valid && rd_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
  end

  // R1: idle walker issues no read
  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_valid);

  // R2, R4: entry addresses are word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[1:0] == 2'b00);

  // R3: missing leaf table means exactly one read
  a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_code == 2'b01) |-> rd_cnt == 2'd1);

  // R5: fault code never carries both bits
  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $onehot0(done_code));

  // R6: offset passes through on success
  a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_code == 2'b00) |-> done_paddr[OFF_W-1:0] == done_vaddr[OFF_W-1:0]);

  // R7: no new request accepted mid-walk
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: stalled read holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R9: result strobe is one cycle, then idle
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  // R10: never a third read; success took two
  a_r10_max_two: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |-> rd_cnt < 2'd2);

  a_r10_success_two: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_code == 2'b00) |-> rd_cnt == 2'd2);

endmodule

bind vxlate_walker vxlate_walker_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .done_valid (done_valid),
  .done_code  (done_code),
  .done_paddr (done_paddr),
  .done_vaddr (done_vaddr)
);

// File: tb/sim_vxlate_walker.sv
`timescale 1ns/1ps
module sim_vxlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_ptr = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        done_valid;
  logic [31:0] done_paddr;
  logic [31:0] done_vaddr;
  logic [1:0]  done_code;

  int vectors = 0;
  int miscmp  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  vxlate_walker u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      miscmp++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  // Runs one walk; memory answers first read with oe, second with ie.
  task automatic run_walk(input logic [31:0] va, input logic [31:0] rp,
                          input logic [31:0] oe, input logic [31:0] ie,
                          input int lr, input int lx, input bit poke,
                          output logic [1:0] code, output logic [31:0] pa,
                          output logic [31:0] vo, output int nrd,
                          output logic [31:0] a1, output logic [31:0] a2,
                          output int hold_err, output int busy_err);
    bit fin = 0;
    logic [31:0] a;
    nrd = 0; hold_err = 0; busy_err = 0; a1 = '0; a2 = '0;
    code = 2'b11; pa = '0; vo = '0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; root_ptr = rp;
    @(negedge clk);
    req_valid = poke; req_vaddr = ~va; root_ptr = ~rp;
    for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
      if (done_valid) begin
        req_valid = 1'b0;
        code = done_code; pa = done_paddr; vo = done_vaddr; fin = 1;
      end else if (rd_valid) begin
        if (req_ready) busy_err++;
        a = rd_addr;
        for (int k = 0; k < lr; k++) begin
          @(negedge clk);
          if (!rd_valid || rd_addr !== a) hold_err++;
        end
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        nrd++;
        if (nrd == 1) a1 = a; else a2 = a;
        repeat (lx) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = (nrd == 1) ? oe : ie;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_data  = 32'hFFFF_FFFF;
      end else begin
        if (req_ready) busy_err++;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    if (!fin) busy_err += 100;
    @(negedge clk);
    chk("R9 strobe one cycle", {31'd0, done_valid}, 32'd0);
    chk("R9 idle after result", {31'd0, req_ready}, 32'd1);
  endtask

  function automatic logic [31:0] dir_addr(logic [31:0] rp, logic [31:0] va);
    return (rp & 32'hFFFF_F000) + ((va >> 22) * 4);
  endfunction
  function automatic logic [31:0] leaf_addr(logic [31:0] oe, logic [31:0] va);
    return (oe & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 4);
  endfunction

  task automatic t_success(input logic [31:0] va, input logic [31:0] rp,
                           input logic [31:0] oe, input logic [31:0] ie,
                           input int lr, input int lx, input bit poke);
    logic [1:0] c; logic [31:0] pa, vo, a1, a2; int n, he, be;
    run_walk(va, rp, oe, ie, lr, lx, poke, c, pa, vo, n, a1, a2, he, be);
    chk("R2 directory address", a1, dir_addr(rp, va));
    chk("R4 leaf address", a2, leaf_addr(oe, va));
    chk("R6 code ok", {30'd0, c}, 32'd0);
    chk("R6 physical address", pa, (ie & 32'hFFFF_F000) | (va & 32'hFFF));
    chk("R9 done vaddr", vo, va);
    chk("R10 two reads", n, 2);
    chk("R8 read held while stalled", he, 0);
    chk("R7 busy while walking", be, 0);
  endtask

  task automatic t_no_table(input logic [31:0] va, input logic [31:0] rp, input int lr);
    logic [1:0] c; logic [31:0] pa, vo, a1, a2; int n, he, be;
    run_walk(va, rp, 32'h0009_9FFE, 32'h0000_0001, lr, 1, 1'b0, c, pa, vo, n, a1, a2, he, be);
    chk("R2 directory address", a1, dir_addr(rp, va));
    chk("R3 code table missing", {30'd0, c}, 32'd1);
    chk("R3 single read", n, 1);
    chk("R3 faulting vaddr", vo, va);
    chk("R8 read held while stalled", he, 0);
  endtask

  task automatic t_no_page(input logic [31:0] va, input logic [31:0] rp, input logic [31:0] oe);
    logic [1:0] c; logic [31:0] pa, vo, a1, a2; int n, he, be;
    run_walk(va, rp, oe, 32'h7777_7FFE, 2, 2, 1'b0, c, pa, vo, n, a1, a2, he, be);
    chk("R4 leaf address", a2, leaf_addr(oe, va));
    chk("R5 code page missing", {30'd0, c}, 32'd2);
    chk("R5 faulting vaddr", vo, va);
    chk("R10 two reads", n, 2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 no read after reset", {31'd0, rd_valid}, 32'd0);
    chk("R1 no result after reset", {31'd0, done_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_success(32'h1234_5678, 32'h0004_0000, 32'h0008_8001, 32'hABCD_E001, 0, 0, 1'b0);
    t_success(32'h8040_2ABC, 32'h0010_0000, 32'h0020_3001, 32'h0055_5003, 3, 5, 1'b0);
    t_success(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0FFF, 1, 0, 1'b0);
    t_success(32'h0000_0000, 32'h0000_0ABC, 32'h0000_1FFF, 32'hF000_0001, 0, 2, 1'b0);
    t_success(32'h0C03_3333, 32'h0007_0000, 32'h0001_2001, 32'h0004_4001, 2, 1, 1'b1);
    t_no_table(32'hDEAD_BEEF, 32'h0003_0000, 0);
    t_no_table(32'h0040_1000, 32'h0003_0FFF, 4);
    t_no_page(32'h1357_9BDF, 32'h0002_0000, 32'h0003_3003);
    t_success(32'h4000_1001, 32'h0001_0000, 32'h0002_0001, 32'h0003_0001, 0, 0, 1'b0);
    t_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule